// File: doc/BRIEF.md
# Victim-Aggressor Data Pattern Generator

This block produces one data word per beat for memory signal-integrity traffic. The same word serves as write data and as the expected value for read-back. A base data pattern sets the waveform: a linear count, a PRBS sequence, a walking one or zero, or a hammer toggle. A victim mode then gives every bit lane a role. Victim lanes carry the waveform. Aggressor lanes are held high or low, copy the victim, invert it, or lag it. In one mode the victim lags the aggressors instead.

The victim lane can be a fixed index supplied from outside. It can also be one lane per nibble, one lane per byte, or one lane across the whole word, and in those three cases it moves up by one lane each time the base pattern completes a full pass. An advance strobe steps the pattern by one beat. A restart strobe returns the pattern, the rotation and the delay history to their beat-zero state, so the read pass regenerates exactly the words that were written. The output is decoded combinationally from registered state and the current settings, and it changes only when a strobe arrives or a setting changes.

Top module: `vag_pattern_gen`

## Requirements
- R1: After reset, and in the cycle after a restart strobe, the generator is at beat zero: count 0, PRBS state 1, rotation position 0 and delay history all zero. Restart takes priority over a simultaneous advance. With data mode 0 and victim mode 0, the beat-zero word is all zeros.
- R2: Data mode 0 (linear) outputs the beat count modulo 2^W. A pass completes every 2^LIN_PASS_LOG2 beats.
- R3: Data mode 1 (PRBS) runs a shift-left Fibonacci register of order PRBS_ORDER (8, 10 or 23) seeded with 1, using taps x^8+x^6+x^5+x^4+1, x^10+x^7+1 or x^23+x^18+1. Output bit i is register bit i mod PRBS_ORDER. A pass completes when the register returns to the seed.
- R4: Data modes 2 and 3 (walking one and walking zero) set, or respectively clear, only bit (beat mod W). A pass completes every W beats.
- R5: Data modes 4 and 5 (hammer) give all-ones and all-zeros on alternate beats. Mode 4 starts with ones and mode 5 starts with zeros. A pass completes every 2 beats.
- R6: Data modes 6 to 15 are reserved and give an all-zero base word with no pass events.
- R7: Victim mode 0, the reserved victim mode 7 and the reserved victim selects 4 to 7 all output the base word unchanged.
- R8: Victim mode 1 forces every aggressor lane to 1, and victim mode 2 forces every aggressor lane to 0. In both modes victim lanes carry the base bit.
- R9: Victim mode 3 makes each aggressor lane equal to its group's victim bit. Victim mode 4 makes each aggressor lane equal to the inverse of that bit.
- R10: Victim mode 5 makes aggressors equal to the group's victim bit from N advances earlier, where N is the 5-bit delay. N = 0 means no lag, and values above 24 act as 24. Lag history recorded before a restart reads as zero.
- R11: Victim mode 6 drives each victim lane with the group's victim bit from N advances earlier. Aggressors carry the current victim bit.
- R12: Victim select 0 uses the external lane index over the whole word. Select 1 picks lane (4g + pos mod 4) in each nibble g, select 2 picks lane (8g + pos mod 8) in each byte g, and select 3 picks lane pos of the word. The position pos starts at 0 and increases by one, modulo W, on each advance that completes a pass.
- R13: Without an advance or restart strobe, and with unchanged settings, the output word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Step the pattern by one beat |
| restart_i | input | 1 | Return to beat zero (wins over adv_i) |
| data_mode_i | input | 4 | Base data pattern select |
| vic_mode_i | input | 3 | Aggressor/victim relationship select |
| vic_sel_i | input | 3 | Victim lane placement select |
| agg_dly_i | input | 5 | Lag N in beats for victim modes 5 and 6 |
| ext_vic_i | input | log2(W) (5) | Victim lane index for select 0 |
| data_o | output | W (32) | Generated data word |

## Verification
The bench goes after pass boundaries, where rotation must step exactly once. A generator that counts the pass one beat early or late, or steps the rotation on every beat, moves the victim to the wrong lane, and aggressor-copy runs show this across the whole word. The lag taps are tested at 0, 1, 9, the limit 24 and the out-of-range 31. An off-by-one tap or a missing clamp shifts the aggressor waveform in time, and a history that restart does not clear leaks old bits into the first beats. A restart together with an advance must land on beat zero, and reserved mode and select codes must fall back to the plain base or zero word instead of producing stray victim structure.

// File: rtl/vag_pkg.sv
package vag_pkg;

   // Base data pattern codes
   localparam logic [3:0] DM_LINEAR  = 4'd0;
   localparam logic [3:0] DM_PRBS    = 4'd1;
   localparam logic [3:0] DM_WALK1   = 4'd2;
   localparam logic [3:0] DM_WALK0   = 4'd3;
   localparam logic [3:0] DM_HAMMER1 = 4'd4;
   localparam logic [3:0] DM_HAMMER0 = 4'd5;

   // Aggressor/victim relationship codes
   localparam logic [2:0] VM_NONE    = 3'd0;
   localparam logic [2:0] VM_HELD1   = 3'd1;
   localparam logic [2:0] VM_HELD0   = 3'd2;
   localparam logic [2:0] VM_COPY    = 3'd3;
   localparam logic [2:0] VM_INVERT  = 3'd4;
   localparam logic [2:0] VM_LAG_AGG = 3'd5;
   localparam logic [2:0] VM_LAG_VIC = 3'd6;

   // Victim placement codes
   localparam logic [2:0] VS_EXTERNAL = 3'd0;
   localparam logic [2:0] VS_NIBBLE   = 3'd1;
   localparam logic [2:0] VS_BYTE     = 3'd2;
   localparam logic [2:0] VS_WORD     = 3'd3;

   // Width of the lag field
   localparam int DLY_W = 5;

endpackage

// File: rtl/vag_base_gen.sv
module vag_base_gen
   import vag_pkg::*;
#(
   parameter int W             = 32,
   parameter int PRBS_ORDER    = 8,
   parameter int LIN_PASS_LOG2 = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         adv_i,
   input  logic         restart_i,
   input  logic [3:0]   dmode_i,
   output logic [W-1:0] base_o,
   output logic         pass_o
);

   localparam int LW = $clog2(W);
   localparam logic [PRBS_ORDER-1:0] SEED = PRBS_ORDER'(1);

   logic [W-1:0]          cnt_q;
   logic [PRBS_ORDER-1:0] lfsr_q;
   logic [PRBS_ORDER-1:0] lfsr_nx;
   logic                  fb;
   logic [W-1:0]          prbs_word;
   logic [W-1:0]          walk_word;
   logic                  pass_hit;

   // Feedback taps chosen by the register order
   generate
      if (PRBS_ORDER == 8) begin : g_p8
         assign fb = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];
      end else if (PRBS_ORDER == 10) begin : g_p10
         assign fb = lfsr_q[9] ^ lfsr_q[6];
      end else begin : g_p23
         assign fb = lfsr_q[22] ^ lfsr_q[17];
      end
   endgenerate

   assign lfsr_nx = {lfsr_q[PRBS_ORDER-2:0], fb};

   // Spread the register over the word
   generate
      for (genvar i = 0; i < W; i++) begin : g_spread
         assign prbs_word[i] = lfsr_q[i % PRBS_ORDER];
      end
   endgenerate

   assign walk_word = W'(1) << cnt_q[LW-1:0];

   always_comb begin
      case (dmode_i)
         DM_LINEAR:  base_o = cnt_q;
         DM_PRBS:    base_o = prbs_word;
         DM_WALK1:   base_o = walk_word;
         DM_WALK0:   base_o = ~walk_word;
         DM_HAMMER1: base_o = cnt_q[0] ? '0 : '1;
         DM_HAMMER0: base_o = cnt_q[0] ? '1 : '0;
         default:    base_o = '0;
      endcase
   end

   // Last beat of a full pass of the current pattern
   always_comb begin
      case (dmode_i)
         DM_LINEAR:              pass_hit = &cnt_q[LIN_PASS_LOG2-1:0];
         DM_PRBS:                pass_hit = (lfsr_nx == SEED);
         DM_WALK1, DM_WALK0:     pass_hit = &cnt_q[LW-1:0];
         DM_HAMMER1, DM_HAMMER0: pass_hit = cnt_q[0];
         default:                pass_hit = 1'b0;
      endcase
   end

   assign pass_o = adv_i & ~restart_i & pass_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         lfsr_q <= SEED;
      end else if (restart_i) begin
         cnt_q  <= '0;
         lfsr_q <= SEED;
      end else if (adv_i) begin
         cnt_q  <= cnt_q + W'(1);
         lfsr_q <= lfsr_nx;
      end
   end

endmodule

// File: rtl/vag_victim_map.sv
module vag_victim_map
   import vag_pkg::*;
#(
   parameter int W = 32
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 restart_i,
   input  logic                 pass_i,
   input  logic [2:0]           sel_i,
   input  logic [$clog2(W)-1:0] ext_i,
   input  logic [W-1:0]         base_i,
   output logic [W-1:0]         vic_mask_o,
   output logic [W-1:0]         wave_o,
   output logic                 map_ok_o
);

   localparam int LW = $clog2(W);

   logic [LW-1:0] pos_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q <= '0;
      end else if (restart_i) begin
         pos_q <= '0;
      end else if (pass_i) begin
         pos_q <= pos_q + LW'(1);
      end
   end

   assign map_ok_o = (sel_i <= VS_WORD);

   // Each lane finds the victim of its group
   generate
      for (genvar i = 0; i < W; i++) begin : g_lane
         localparam int NIB_BASE  = (i / 4) * 4;
         localparam int BYTE_BASE = (i / 8) * 8;
         logic [LW-1:0] v_idx;

         always_comb begin
            case (sel_i)
               VS_EXTERNAL: v_idx = ext_i;
               VS_NIBBLE:   v_idx = LW'(NIB_BASE) + LW'(pos_q[1:0]);
               VS_BYTE:     v_idx = LW'(BYTE_BASE) + LW'(pos_q[2:0]);
               default:     v_idx = pos_q;
            endcase
         end

         assign vic_mask_o[i] = (v_idx == LW'(i));
         assign wave_o[i]     = base_i[v_idx];
      end
   endgenerate

endmodule

// File: rtl/vag_delay_line.sv
module vag_delay_line
   import vag_pkg::*;
#(
   parameter int W     = 32,
   parameter int DEPTH = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             adv_i,
   input  logic             restart_i,
   input  logic [W-1:0]     din_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic [W-1:0]     dout_o
);

   logic [W-1:0]     hist_q [DEPTH];
   logic [DLY_W-1:0] eff;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
      end else if (restart_i) begin
         for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
      end else if (adv_i) begin
         hist_q[0] <= din_i;
         for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
      end
   end

   // Clamp the lag to the depth of the history
   assign eff = (dly_i > DLY_W'(DEPTH)) ? DLY_W'(DEPTH) : dly_i;

   always_comb begin
      dout_o = din_i;
      for (int k = 1; k <= DEPTH; k++) begin
         if (eff == DLY_W'(k)) dout_o = hist_q[k-1];
      end
   end

endmodule

// File: rtl/vag_pattern_gen.sv
module vag_pattern_gen
   import vag_pkg::*;
#(
   parameter int W             = 32,
   parameter int PRBS_ORDER    = 8,
   parameter int LIN_PASS_LOG2 = 4,
   parameter int DLY_DEPTH     = 24
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 adv_i,
   input  logic                 restart_i,
   input  logic [3:0]           data_mode_i,
   input  logic [2:0]           vic_mode_i,
   input  logic [2:0]           vic_sel_i,
   input  logic [4:0]           agg_dly_i,
   input  logic [$clog2(W)-1:0] ext_vic_i,
   output logic [W-1:0]         data_o
);

   localparam int LW = $clog2(W);

   // Elaboration-time parameter checks
   generate
      if ((1 << LW) != W || W < 8) begin : g_bad_w
         $error("W must be a power of two and at least 8");
      end
      if (PRBS_ORDER != 8 && PRBS_ORDER != 10 && PRBS_ORDER != 23) begin : g_bad_prbs
         $error("PRBS_ORDER must be 8, 10 or 23");
      end
      if (DLY_DEPTH < 1 || DLY_DEPTH >= (1 << DLY_W)) begin : g_bad_dly
         $error("DLY_DEPTH out of range for the lag field");
      end
      if (LIN_PASS_LOG2 < 1 || LIN_PASS_LOG2 > W) begin : g_bad_lin
         $error("LIN_PASS_LOG2 out of range");
      end
   endgenerate

   logic [W-1:0] base_w;
   logic [W-1:0] vic_mask;
   logic [W-1:0] wave_w;
   logic [W-1:0] lag_w;
   logic         pass_w;
   logic         map_ok;
   logic         roles_on;

   vag_base_gen #(
      .W             (W),
      .PRBS_ORDER    (PRBS_ORDER),
      .LIN_PASS_LOG2 (LIN_PASS_LOG2)
   ) u_base (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (adv_i),
      .restart_i (restart_i),
      .dmode_i   (data_mode_i),
      .base_o    (base_w),
      .pass_o    (pass_w)
   );

   vag_victim_map #(
      .W (W)
   ) u_map (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (restart_i),
      .pass_i     (pass_w),
      .sel_i      (vic_sel_i),
      .ext_i      (ext_vic_i),
      .base_i     (base_w),
      .vic_mask_o (vic_mask),
      .wave_o     (wave_w),
      .map_ok_o   (map_ok)
   );

   vag_delay_line #(
      .W     (W),
      .DEPTH (DLY_DEPTH)
   ) u_lag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (adv_i),
      .restart_i (restart_i),
      .din_i     (wave_w),
      .dly_i     (agg_dly_i),
      .dout_o    (lag_w)
   );

   assign roles_on = map_ok && (vic_mode_i >= VM_HELD1) && (vic_mode_i <= VM_LAG_VIC);

   // Per-lane role combine
   generate
      for (genvar i = 0; i < W; i++) begin : g_out
         logic agg_bit;
         logic vic_bit;

         always_comb begin
            case (vic_mode_i)
               VM_HELD1:   agg_bit = 1'b1;
               VM_HELD0:   agg_bit = 1'b0;
               VM_COPY:    agg_bit = wave_w[i];
               VM_INVERT:  agg_bit = ~wave_w[i];
               VM_LAG_AGG: agg_bit = lag_w[i];
               default:    agg_bit = wave_w[i];
            endcase
            vic_bit = (vic_mode_i == VM_LAG_VIC) ? lag_w[i] : wave_w[i];
         end

         assign data_o[i] = !roles_on   ? base_w[i] :
                            vic_mask[i] ? vic_bit   : agg_bit;
      end
   endgenerate

endmodule

// File: rtl/vag_pattern_gen_chk.sv
module vag_pattern_gen_chk #(
   parameter int W = 32
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 adv_i,
   input logic                 restart_i,
   input logic [3:0]           data_mode_i,
   input logic [2:0]           vic_mode_i,
   input logic [2:0]           vic_sel_i,
   input logic [4:0]           agg_dly_i,
   input logic [$clog2(W)-1:0] ext_vic_i,
   input logic [W-1:0]         data_o
);

   logic [W-1:0] ext_hot;
   assign ext_hot = W'(1) << ext_vic_i;

   assert_restart_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (data_mode_i != 4'd0 || vic_mode_i != 3'd0 || data_o == '0));

   assert_hammer_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !restart_i && vic_mode_i == 3'd0 &&
       (data_mode_i == 4'd4 || data_mode_i == 4'd5))
      |=> (!$stable(data_mode_i) || !$stable(vic_mode_i) || data_o == ~$past(data_o)));

   assert_reserved_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_mode_i >= 4'd6 && vic_mode_i == 3'd0) |-> data_o == '0);

   assert_held_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vic_mode_i == 3'd1 && vic_sel_i == 3'd0) |-> ((data_o | ext_hot) == '1));

   assert_held_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vic_mode_i == 3'd2 && vic_sel_i == 3'd0) |-> ((data_o & ~ext_hot) == '0));

   assert_invert_aggr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vic_mode_i == 3'd4 && vic_sel_i == 3'd0)
      |-> ((data_o ^ {W{~data_o[ext_vic_i]}}) == ext_hot));

   assert_hold_stable_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!adv_i && !restart_i)
      |=> (!$stable({data_mode_i, vic_mode_i, vic_sel_i, agg_dly_i, ext_vic_i}) ||
           $stable(data_o)));

endmodule

bind vag_pattern_gen vag_pattern_gen_chk #(.W(W)) u_chk (.*);

// File: tb/vag_pattern_gen_tb.sv
`timescale 1ns/1ps
module vag_pattern_gen_tb;

   localparam int W  = 32;
   localparam int PO = 8;
   localparam int LP = 16;   // linear pass length
   localparam int DD = 24;   // lag depth

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         adv = 1'b0;
   logic         rst_p = 1'b0;
   logic [3:0]   dm = '0;
   logic [2:0]   vm = '0;
   logic [2:0]   vs = '0;
   logic [4:0]   dly = '0;
   logic [4:0]   ext = '0;
   logic [W-1:0] data_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   vag_pattern_gen u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .adv_i       (adv),
      .restart_i   (rst_p),
      .data_mode_i (dm),
      .vic_mode_i  (vm),
      .vic_sel_i   (vs),
      .agg_dly_i   (dly),
      .ext_vic_i   (ext),
      .data_o      (data_o)
   );

   // ---------------- reference model ----------------
   logic [W-1:0]  m_cnt;
   logic [PO-1:0] m_lfsr;
   int            m_pos;
   logic [W-1:0]  m_hist [DD];

   function automatic void m_reset();
      m_cnt  = '0;
      m_lfsr = PO'(1);
      m_pos  = 0;
      for (int j = 0; j < DD; j++) m_hist[j] = '0;
   endfunction

   function automatic logic [PO-1:0] m_lfsr_next();
      logic f;
      f = m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3];
      return {m_lfsr[PO-2:0], f};
   endfunction

   function automatic logic [W-1:0] m_base();
      logic [W-1:0] r;
      r = '0;
      case (int'(dm))
         0: r = m_cnt;
         1: for (int i = 0; i < W; i++) r[i] = m_lfsr[i % PO];
         2: r[int'(m_cnt % W)] = 1'b1;
         3: begin r = '1; r[int'(m_cnt % W)] = 1'b0; end
         4: r = m_cnt[0] ? '0 : '1;
         5: r = m_cnt[0] ? '1 : '0;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic int victim_of(int i);
      case (int'(vs))
         0: return int'(ext);
         1: return (i / 4) * 4 + (m_pos % 4);
         2: return (i / 8) * 8 + (m_pos % 8);
         3: return m_pos;
         default: return -1;
      endcase
   endfunction

   function automatic logic [W-1:0] m_wave();
      logic [W-1:0] b, wv;
      int v;
      b = m_base();
      for (int i = 0; i < W; i++) begin
         v = victim_of(i);
         wv[i] = (v < 0) ? b[i] : b[v];
      end
      return wv;
   endfunction

   function automatic logic [W-1:0] m_word();
      logic [W-1:0] b, wv, w;
      int v, n;
      logic d;
      b  = m_base();
      wv = m_wave();
      n  = (int'(dly) > DD) ? DD : int'(dly);
      for (int i = 0; i < W; i++) begin
         v = victim_of(i);
         if (v < 0 || vm == 3'd0 || vm == 3'd7) begin
            w[i] = b[i];
         end else begin
            d = (n == 0) ? wv[i] : m_hist[n-1][i];
            if (i == v) w[i] = (vm == 3'd6) ? d : wv[i];
            else begin
               case (int'(vm))
                  1: w[i] = 1'b1;
                  2: w[i] = 1'b0;
                  4: w[i] = ~wv[i];
                  5: w[i] = d;
                  default: w[i] = wv[i];
               endcase
            end
         end
      end
      return w;
   endfunction

   function automatic void m_step();
      logic [W-1:0] wv;
      logic pass;
      wv = m_wave();
      case (int'(dm))
         0:    pass = ((m_cnt % LP) == LP - 1);
         1:    pass = (m_lfsr_next() == PO'(1));
         2, 3: pass = ((m_cnt % W) == W - 1);
         4, 5: pass = m_cnt[0];
         default: pass = 1'b0;
      endcase
      for (int j = DD - 1; j > 0; j--) m_hist[j] = m_hist[j-1];
      m_hist[0] = wv;
      m_cnt  = m_cnt + W'(1);
      m_lfsr = m_lfsr_next();
      if (pass) m_pos = (m_pos + 1) % W;
   endfunction

   // ---------------- scoreboard ----------------
   logic [W-1:0] q_exp [$];
   string        q_tag [$];

   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [W-1:0] e;
         string tg;
         e  = q_exp.pop_front();
         tg = q_tag.pop_front();
         n_tests++;
         if (data_o !== e) begin
            n_fail++;
            $display("FAIL %s: data_o=%h expected=%h (dm=%0d vm=%0d vs=%0d dly=%0d ext=%0d)",
                     tg, data_o, e, dm, vm, vs, dly, ext);
         end
      end
   end

   task automatic push_exp(string tag);
      q_exp.push_back(m_word());
      q_tag.push_back(tag);
      @(negedge clk);
      #1;
   endtask

   task automatic do_beat(string tag);
      @(posedge clk); #2;
      adv = 1'b1;
      @(posedge clk); #2;
      adv = 1'b0;
      m_step();
      push_exp(tag);
   endtask

   task automatic do_restart(string tag);
      @(posedge clk); #2;
      rst_p = 1'b1;
      @(posedge clk); #2;
      rst_p = 1'b0;
      m_reset();
      push_exp(tag);
   endtask

   task automatic set_cfg(int d, int v, int s, int n, int e);
      @(posedge clk); #2;
      dm  = 4'(d);
      vm  = 3'(v);
      vs  = 3'(s);
      dly = 5'(n);
      ext = 5'(e);
   endtask

   function automatic string tag_for(int d, int v, int s);
      if (d >= 6) return "R6";
      if (v == 7 || s >= 4) return "R7";
      if (v == 0) begin
         if (d == 0) return "R2";
         if (d == 1) return "R3";
         if (d <= 3) return "R4";
         return "R5";
      end
      if (v == 3 && s >= 1) return "R12";
      if (v == 1 || v == 2) return "R8";
      if (v <= 4) return "R9";
      if (v == 5) return "R10";
      return "R11";
   endfunction

   // ---------------- stimulus ----------------
   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset state, linear with no roles gives zero
      push_exp("R1");

      // R2: linear count over more than one pass
      for (int b = 0; b < 20; b++) do_beat("R2");

      // R1: restart together with advance lands on beat zero
      @(posedge clk); #2;
      adv = 1'b1; rst_p = 1'b1;
      @(posedge clk); #2;
      adv = 1'b0; rst_p = 1'b0;
      m_reset();
      push_exp("R1");

      // R13: output holds without strobes
      set_cfg(1, 3, 3, 0, 0);
      for (int b = 0; b < 5; b++) do_beat("R3");
      repeat (4) @(posedge clk);
      push_exp("R13");
      repeat (7) @(posedge clk);
      push_exp("R13");

      // R3 / R12: long PRBS run crossing a full pass with whole-word rotation
      do_restart("R1");
      for (int b = 0; b < 300; b++) do_beat("R12");

      // Mode sweep
      for (int d = 0; d < 8; d++) begin
         for (int v = 0; v < 8; v++) begin
            for (int s = 0; s < 5; s++) begin
               int n, e;
               case ((d + v + s) % 5)
                  0: n = 0;
                  1: n = 1;
                  2: n = 9;
                  3: n = 24;
                  default: n = 31;
               endcase
               e = (d * 7 + v * 3 + s * 5) % W;
               set_cfg(d, v, s, n, e);
               do_restart("R1");
               for (int b = 0; b < 38; b++) do_beat(tag_for(d, v, s));
            end
         end
      end

      // R10: lag clamp and lag change mid-run
      set_cfg(2, 5, 0, 31, 6);
      do_restart("R1");
      for (int b = 0; b < 30; b++) do_beat("R10");
      set_cfg(2, 5, 0, 3, 6);
      push_exp("R10");
      // R11: lagged victim under byte rotation
      set_cfg(4, 6, 2, 5, 0);
      for (int b = 0; b < 20; b++) do_beat("R11");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule